// File: doc/BRIEF.md
# Rotating Polled Interrupt Input Scanner

This block collects a set of interrupt request lines and hands them one at a time to a message sender. Each line has a configuration slot with the same index. The slot holds the trigger mode (edge or level), the active polarity, a mask bit, an interrupt vector and a destination field. Raw inputs pass through a two-flop synchronizer. The active polarity is then applied. An edge-mode line latches a pending flag on each inactive-to-active transition. A level-mode line counts as pending for as long as it stays active, unless it is waiting for service completion.

A scan pointer visits one line per clock and moves around all lines in a circle. The first pending line it reaches becomes the outgoing request. The request carries the line index, that slot's vector and destination, and the trigger mode. It is offered on a valid/ready handshake. The vector and the line number give no priority.

While a request is waiting, the pointer stays where it is. After acceptance, scanning resumes at the line after the one sent. An accepted level request marks its line as in service. An end-of-service pulse that carries a matching vector clears that mark. Slots are written through a single-cycle write port.

Top module: `irq_rr_scanner`

## Requirements
- R1: After reset, `req_valid` is 0 and every slot is masked, edge mode, active high, with vector 0 and destination 0. No input activity produces a request until a slot is unmasked.
- R2: An edge-mode, unmasked line produces exactly one request for each inactive-to-active transition. The flag clears when that request is accepted, and a line held active afterwards does not request again.
- R3: An unmasked level-mode line that is active produces a request with `req_level`=1. It then produces no further request until `eoi_valid` arrives with `eoi_vector` equal to that slot's vector. If the line is still active at that point, it requests again. If it is inactive, nothing is sent.
- R4: When `cfg_low` is 1, logic 0 on the input is the active level, so a falling raw input is the transition that counts for edge mode.
- R5: A masked line is never selected. Edges that arrive while a line is masked are discarded, and unmasking the line later does not send them.
- R6: After the request for line L is accepted, the next request is the first pending line found in the order L+1, L+2, … with wrap from N-1 to 0. Vector values have no influence on that order.
- R7: While `req_valid`=1 and `req_ready`=0, `req_valid`, `req_line`, `req_vector`, `req_dest` and `req_level` hold steady. Acceptance happens on a clock edge where both are 1. The cycle after acceptance, `req_valid` is 0 and the pointer is at L+1 (mod N).
- R8: `req_vector` and `req_dest` equal the vector and destination written to slot `req_line`.
- R9: An end-of-service pulse whose vector does not match a level slot's vector leaves that slot in service.
- R10: A change on a raw input cannot cause `req_valid` to rise at either of the two clock edges that follow the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Raw asynchronous interrupt lines |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | IW | Slot index to write |
| cfg_level | input | 1 | 1 = level mode, 0 = edge mode |
| cfg_low | input | 1 | 1 = low level is active |
| cfg_mask | input | 1 | 1 = line masked |
| cfg_vector | input | VEC_W | Vector stored for the slot |
| cfg_dest | input | DEST_W | Destination stored for the slot |
| eoi_valid | input | 1 | End-of-service pulse |
| eoi_vector | input | VEC_W | Vector whose service has ended |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Sender takes the request |
| req_line | output | IW | Index of the requesting line |
| req_vector | output | VEC_W | Vector of that line |
| req_dest | output | DEST_W | Destination of that line |
| req_level | output | 1 | Trigger mode of that line |

## Verification
The bench builds the block with its default values: N=24, and 8-bit vector and destination fields. Twenty-four lines are few enough that a single held request lets the bench load every line at once and then drain a full turn of the circle. That exercises the wrap from line 23 back to line 0 and the resume point after each acceptance. The 8-bit vector width leaves room for a distinct vector in every slot, so any mismatch between the selected line and its stored vector or destination shows up directly at the outputs.

// File: rtl/irq_rr_scanner.sv
module irq_rr_scanner #(
  parameter int N      = 24,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic              cfg_level,
  input  logic              cfg_low,
  input  logic              cfg_mask,
  input  logic [VEC_W-1:0]  cfg_vector,
  input  logic [DEST_W-1:0] cfg_dest,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IW-1:0]     req_line,
  output logic [VEC_W-1:0]  req_vector,
  output logic [DEST_W-1:0] req_dest,
  output logic              req_level
);

  logic [N-1:0]      sync1, sync2, prev_act;
  logic [N-1:0]      lvl_q, low_q, mask_q, edge_q, busy_q;
  logic [VEC_W-1:0]  vec_q  [N];
  logic [DEST_W-1:0] dest_q [N];
  logic [IW-1:0]     ptr;

  logic [N-1:0] act, rise, pend;
  logic         accept;
  logic [IW-1:0] ptr_nxt;

  assign act     = sync2 ^ low_q;
  assign rise    = act & ~prev_act;
  assign pend    = ~mask_q & ((lvl_q & act & ~busy_q) | (~lvl_q & edge_q));
  assign accept  = req_valid & req_ready;
  assign ptr_nxt = (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1    <= '0;
      sync2    <= '0;
      prev_act <= '0;
    end else begin
      sync1    <= irq_in;
      sync2    <= sync1;
      prev_act <= act;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      low_q  <= '0;
      mask_q <= '1;
      for (int i = 0; i < N; i++) begin
        vec_q[i]  <= '0;
        dest_q[i] <= '0;
      end
    end else if (cfg_we) begin
      lvl_q[cfg_idx]  <= cfg_level;
      low_q[cfg_idx]  <= cfg_low;
      mask_q[cfg_idx] <= cfg_mask;
      vec_q[cfg_idx]  <= cfg_vector;
      dest_q[cfg_idx] <= cfg_dest;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      busy_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (accept && req_line == IW'(i)) begin
          edge_q[i] <= 1'b0;
          if (req_level) busy_q[i] <= 1'b1;
        end
        if (eoi_valid && lvl_q[i] && vec_q[i] == eoi_vector) busy_q[i] <= 1'b0;
        if (!lvl_q[i] && !mask_q[i] && rise[i]) edge_q[i] <= 1'b1;
        if (mask_q[i] || lvl_q[i]) edge_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      req_valid  <= 1'b0;
      req_line   <= '0;
      req_vector <= '0;
      req_dest   <= '0;
      req_level  <= 1'b0;
    end else if (req_valid) begin
      if (req_ready) begin
        req_valid <= 1'b0;
        ptr       <= ptr_nxt;
      end
    end else if (pend[ptr]) begin
      req_valid  <= 1'b1;
      req_line   <= ptr;
      req_vector <= vec_q[ptr];
      req_dest   <= dest_q[ptr];
      req_level  <= lvl_q[ptr];
    end else begin
      ptr <= ptr_nxt;
    end
  end

endmodule

// File: rtl/irq_rr_scanner_chk.sv
module irq_rr_scanner_chk #(
  parameter int N      = 24,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IW-1:0]     req_line,
  input logic [VEC_W-1:0]  req_vector,
  input logic [DEST_W-1:0] req_dest,
  input logic              req_level,
  input logic [IW-1:0]     ptr,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      busy_q
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line) && $stable(req_vector)
                                   && $stable(req_dest) && $stable(req_level)));

  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid &&
      ptr == (($past(req_line) == IW'(N - 1)) ? '0 : $past(req_line) + 1'b1)));

  p_line_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_line) < N));

  p_not_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (($past(mask_q) & (N'(1) << req_line)) == '0));

  p_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_level) |-> (($past(busy_q) & (N'(1) << req_line)) == '0));

endmodule

bind irq_rr_scanner irq_rr_scanner_chk #(.N(N), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_line(req_line), .req_vector(req_vector), .req_dest(req_dest),
  .req_level(req_level), .ptr(ptr), .mask_q(mask_q), .busy_q(busy_q)
);

// File: tb/sim_irq_rr_scanner.sv
module sim_irq_rr_scanner;
  localparam int CLK_P = 10;
  localparam int N = 24;
  localparam int IW = 5;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic cfg_we = 0, cfg_level = 0, cfg_low = 0, cfg_mask = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0] cfg_vector = '0, cfg_dest = '0, eoi_vector = '0;
  logic eoi_valid = 0, req_ready = 0;
  logic req_valid, req_level;
  logic [IW-1:0] req_line;
  logic [7:0] req_vector, req_dest;

  irq_rr_scanner u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_level(cfg_level), .cfg_low(cfg_low), .cfg_mask(cfg_mask),
    .cfg_vector(cfg_vector), .cfg_dest(cfg_dest), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_vector(req_vector), .req_dest(req_dest),
    .req_level(req_level)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [7:0] vec_of(int i); return 8'(8'h20 + i * 3); endfunction
  function automatic logic [7:0] dst_of(int i); return 8'(i) ^ 8'h5A; endfunction

  function automatic int next_from(int from, logic [N-1:0] set);
    for (int k = 0; k < N; k++) begin
      int j = (from + k) % N;
      if (set[j]) return j;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic cfg(int idx, bit lvl, bit low, bit msk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_level = lvl; cfg_low = low; cfg_mask = msk;
    cfg_vector = vec_of(idx); cfg_dest = dst_of(idx);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 0;
  endtask

  task automatic wait_valid(output bit got, input int lim);
    got = 0;
    for (int k = 0; k < lim; k++) begin
      if (req_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic take();
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
  endtask

  task automatic expect_grant(int line, bit lvl, string tag);
    bit got;
    wait_valid(got, 200);
    chk(got, tag, int'(got), 1);
    if (got) begin
      chk(int'(req_line) == line, tag, int'(req_line), line);
      chk(req_vector == vec_of(line), {tag, " R8 vector"}, int'(req_vector), int'(vec_of(line)));
      chk(req_dest == dst_of(line), {tag, " R8 dest"}, int'(req_dest), int'(dst_of(line)));
      chk(req_level == lvl, {tag, " level flag"}, int'(req_level), int'(lvl));
      take();
      chk(!req_valid, {tag, " R7 drop after accept"}, int'(req_valid), 0);
    end
  endtask

  task automatic quiet(string tag, int cyc);
    bit seen = 0;
    int ln = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (req_valid && !seen) begin seen = 1; ln = int'(req_line); end
      if (req_valid) take();
    end
    chk(!seen, tag, seen ? ln : -1, -1);
  endtask

  task automatic round(int a, logic [N-1:0] set, logic [N-1:0] msk);
    bit got;
    logic [N-1:0] rest, want;
    int from;
    irq_in[a] = 1; tick(4); irq_in[a] = 0;
    wait_valid(got, 200);
    chk(got && int'(req_line) == a, "R2 first grant", int'(req_line), a);
    for (int i = 0; i < N; i++) if (msk[i]) cfg(i, 0, 0, 1);
    rest = set & ~(N'(1) << a);
    irq_in = rest;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(req_valid && int'(req_line) == a && req_vector == vec_of(a), "R7 hold",
          int'(req_line), a);
    end
    irq_in = '0;
    tick(3);
    take();
    want = rest & ~msk;
    from = a + 1;
    while (want != '0) begin
      int e = next_from(from, want);
      expect_grant(e, 0, "R6 order");
      want[e] = 0;
      from = e + 1;
    end
    for (int i = 0; i < N; i++) if (msk[i]) cfg(i, 0, 0, 0);
    quiet("R5 dropped edges", 40);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1;
    tick(1);
    chk(!req_valid, "R1 reset valid", int'(req_valid), 0);
    irq_in = '1;
    quiet("R1 masked at reset", 50);
    irq_in = '0;
    tick(4);

    for (int i = 0; i < N; i++) cfg(i, 0, 0, 0);
    quiet("R1 no spurious after unmask", 30);

    // R10 latency and R2 single shot
    irq_in[7] = 1;
    @(negedge clk);
    chk(!req_valid, "R10 edge 1", int'(req_valid), 0);
    @(negedge clk);
    chk(!req_valid, "R10 edge 2", int'(req_valid), 0);
    expect_grant(7, 0, "R2 edge line");
    quiet("R2 held high no repeat", 60);
    irq_in[7] = 0;
    tick(4);

    round(22, 24'h00000F | (24'h1 << 23), '0);
    round(5, '1, '0);
    for (int r = 0; r < 6; r++) begin
      logic [N-1:0] s = N'($urandom);
      logic [N-1:0] m = (r >= 3) ? N'($urandom) & N'($urandom) : '0;
      int a = int'($urandom % N);
      round(a, s, m);
    end

    // R4 active low
    cfg(9, 0, 0, 1);
    irq_in[9] = 1; tick(4);
    cfg(9, 0, 1, 0);
    quiet("R4 inactive high", 30);
    irq_in[9] = 0;
    expect_grant(9, 0, "R4 falling edge");
    irq_in[9] = 1;
    quiet("R4 rising ignored", 40);

    // R5 masked level line
    cfg(15, 1, 0, 1);
    irq_in[15] = 1;
    quiet("R5 masked level", 60);
    irq_in[15] = 0; tick(4);

    // R3 / R9 level behaviour
    cfg(15, 1, 0, 0);
    irq_in[15] = 1;
    expect_grant(15, 1, "R3 level grant");
    quiet("R3 in service", 60);
    eoi(vec_of(14));
    quiet("R9 wrong vector", 40);
    eoi(vec_of(15));
    expect_grant(15, 1, "R3 regrant after eoi");
    irq_in[15] = 0; tick(4);
    eoi(vec_of(15));
    quiet("R3 inactive after eoi", 40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule